// File: doc/BRIEF.md
# Graphics DMA Request Generator

This block produces the readiness flags and the DMA request line that sit beside a graphics command unit. It takes the command engine's present state, the number of command words still expected, and the configured DMA direction, and from these it decides whether the unit can accept a new command, can accept DMA words, or has VRAM data ready for the CPU. It then raises the DMA request that fits the selected direction.

Words written to VRAM from the CPU are not free. Each word written while the engine is in its VRAM-write state adds one GPU tick to a blitter busy counter. Each clock cycle, the counter loses as many ticks as the GPU clock advanced in that cycle, which is given by a per-cycle increment input. While the counter is above zero, every ready flag and the DMA request are held low. This gives the CPU side a realistic delay on large uploads.

Top module: `gfx_dreq_gen`

## Requirements
- R1: `rdy_vram_o` is high only when the blitter counter is zero and `state_i` is 2 (reading VRAM).
- R2: `rdy_cmd_o` is high only when the blitter counter is zero and `state_i` is 0 (idle).
- R3: `rdy_dma_o` is high when the blitter counter is zero and either `state_i` is 0, or `state_i` is not 2 and `pend_words_i` is nonzero. It is low otherwise.
- R4: `dir_i` encodings are 0 off, 1 FIFO, 2 CPU-to-command-port and 3 read-port-to-CPU. With `dir_i` = 0, `dreq_o` is low.
- R5: With `dir_i` = 1, `dreq_o` is high when the blitter counter is zero and `state_i` is 2 or 3.
- R6: With `dir_i` = 2, `dreq_o` equals `rdy_dma_o`.
- R7: With `dir_i` = 3, `dreq_o` equals `rdy_vram_o`.
- R8: A clock edge where `wr_stb_i` is high and `state_i` is 3 (writing VRAM) adds `wr_cnt_i` to the counter. A strobe in any other state has no effect on the counter.
- R9: At every clock edge, after any add, the counter is reduced by `tick_inc_i`. A result at or below zero becomes zero.
- R10: The counter is 16 bits wide by default. An add that would overflow it leaves it at the all-ones value instead of wrapping.
- R11: After `rst_ni` is released, the counter is zero, so the outputs depend only on the state, the pending count and the direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| state_i | input | 2 | Engine state: 0 idle, 1 other busy, 2 reading VRAM, 3 writing VRAM |
| pend_words_i | input | PEND_W (8) | Command words still expected |
| dir_i | input | 2 | DMA direction code |
| wr_stb_i | input | 1 | DMA word-burst write strobe |
| wr_cnt_i | input | WCNT_W (8) | Number of words in the burst |
| tick_inc_i | input | TICK_W (4) | GPU ticks elapsed this cycle |
| rdy_cmd_o | output | 1 | Ready to receive a command |
| rdy_vram_o | output | 1 | Ready to send VRAM data |
| rdy_dma_o | output | 1 | Ready to receive DMA words |
| dreq_o | output | 1 | DMA request |

## Verification
The blitter counter can only be seen through the gating of the outputs, so a wrong count shows up as a wrong busy window. A missed add, a drain error or a wrapped overflow makes the ready flags return too early or too late. A dropped clamp at zero shows up the same way. When an add is lost, the flags stay high on the cycle right after the strobe, when they should drop. When the drain rate or the saturation is wrong, the error appears at the cycle the counter should reach zero. For a saturated counter that cycle is thousands of cycles later. The direction decode is a pure function of the present inputs, so a wrong decode is visible in the same cycle.

// File: rtl/gfx_dreq_pkg.sv
package gfx_dreq_pkg;
  // Ordered so that "reading VRAM or later" is a magnitude compare.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_RD   = 2'd2,
    ST_WR   = 2'd3
  } eng_state_e;

  typedef enum logic [1:0] {
    DIR_OFF  = 2'd0,
    DIR_FIFO = 2'd1,
    DIR_CMD  = 2'd2,
    DIR_RD   = 2'd3
  } dma_dir_e;
endpackage

// File: rtl/gfx_blit_timer.sv
module gfx_blit_timer #(
  parameter int CNT_W  = 16,
  parameter int WCNT_W = 8,
  parameter int TICK_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              add_en_i,
  input  logic [WCNT_W-1:0] add_i,
  input  logic [TICK_W-1:0] tick_i,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, sat, tick_x, nxt;
  logic [CNT_W:0]   sum, add_x;

  always_comb begin
    add_x  = add_en_i ? (CNT_W+1)'(add_i) : '0;
    sum    = {1'b0, cnt_q} + add_x;
    sat    = sum[CNT_W] ? MAXV : sum[CNT_W-1:0];
    tick_x = CNT_W'(tick_i);
    nxt    = (tick_x >= sat) ? '0 : sat - tick_x;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= nxt;

  assign cnt_o = cnt_q;

  // R10
  sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == MAXV && add_en_i && tick_i == '0) |=> (cnt_q == MAXV));
  // R9
  drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!add_en_i) |=> (cnt_q <= $past(cnt_q)));
  // R9
  zero_stay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!add_en_i && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/gfx_ready_decode.sv
module gfx_ready_decode
  import gfx_dreq_pkg::*;
#(
  parameter int PEND_W = 8
) (
  input  eng_state_e        state_i,
  input  dma_dir_e          dir_i,
  input  logic [PEND_W-1:0] pend_i,
  input  logic              blit_idle_i,
  output logic              rdy_cmd_o,
  output logic              rdy_vram_o,
  output logic              rdy_dma_o,
  output logic              dreq_o
);
  always_comb begin
    rdy_cmd_o  = blit_idle_i && state_i == ST_IDLE;
    rdy_vram_o = blit_idle_i && state_i == ST_RD;
    rdy_dma_o  = blit_idle_i &&
                 (state_i == ST_IDLE || (state_i != ST_RD && pend_i != '0));
    unique case (dir_i)
      DIR_FIFO: dreq_o = blit_idle_i && state_i >= ST_RD;
      DIR_CMD:  dreq_o = blit_idle_i && rdy_dma_o;
      DIR_RD:   dreq_o = blit_idle_i && rdy_vram_o;
      default:  dreq_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/gfx_dreq_gen.sv
module gfx_dreq_gen
  import gfx_dreq_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int WCNT_W = 8,
  parameter int TICK_W = 4,
  parameter int PEND_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        state_i,
  input  logic [PEND_W-1:0] pend_words_i,
  input  logic [1:0]        dir_i,
  input  logic              wr_stb_i,
  input  logic [WCNT_W-1:0] wr_cnt_i,
  input  logic [TICK_W-1:0] tick_inc_i,
  output logic              rdy_cmd_o,
  output logic              rdy_vram_o,
  output logic              rdy_dma_o,
  output logic              dreq_o
);
  eng_state_e       st;
  dma_dir_e         dir;
  logic [CNT_W-1:0] cnt;
  logic             add_en;

  assign st     = eng_state_e'(state_i);
  assign dir    = dma_dir_e'(dir_i);
  assign add_en = wr_stb_i && st == ST_WR;

  gfx_blit_timer #(.CNT_W(CNT_W), .WCNT_W(WCNT_W), .TICK_W(TICK_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .add_en_i (add_en),
    .add_i    (wr_cnt_i),
    .tick_i   (tick_inc_i),
    .cnt_o    (cnt)
  );

  gfx_ready_decode #(.PEND_W(PEND_W)) u_dec (
    .state_i     (st),
    .dir_i       (dir),
    .pend_i      (pend_words_i),
    .blit_idle_i (cnt == '0),
    .rdy_cmd_o   (rdy_cmd_o),
    .rdy_vram_o  (rdy_vram_o),
    .rdy_dma_o   (rdy_dma_o),
    .dreq_o      (dreq_o)
  );

  // R1
  busy_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt != '0) |-> !(rdy_cmd_o || rdy_vram_o || rdy_dma_o || dreq_o));
  // R2
  rdy_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rdy_cmd_o, rdy_vram_o}));
  // R4
  dir_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_i == 2'd0) |-> !dreq_o);
  // R8
  add_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (add_en && wr_cnt_i != '0 && tick_inc_i == '0) |=> (cnt != '0));
  // R7
  rd_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_i == 2'd3) |-> (dreq_o == rdy_vram_o));
endmodule

// File: tb/sim_gfx_dreq_gen.sv
`timescale 1ns/1ps
module sim_gfx_dreq_gen;
  localparam int MAXV = 65535;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [1:0] state = 2'd0, dir = 2'd0;
  logic [7:0] pend = 8'd0, wcnt = 8'd0;
  logic       stb = 1'b0;
  logic [3:0] tick = 4'd0;
  logic       rdy_cmd, rdy_vram, rdy_dma, dreq;

  int n_chk = 0, n_bad = 0, exp_cnt = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gfx_dreq_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .state_i(state), .pend_words_i(pend),
    .dir_i(dir), .wr_stb_i(stb), .wr_cnt_i(wcnt), .tick_inc_i(tick),
    .rdy_cmd_o(rdy_cmd), .rdy_vram_o(rdy_vram), .rdy_dma_o(rdy_dma), .dreq_o(dreq)
  );

  function automatic int next_cnt(int c, logic [1:0] s, logic st_b, int w, int t);
    int v = c;
    if (st_b && s == 2'd3) v = v + w;   // R8
    if (v > MAXV) v = MAXV;             // R10
    v = v - t;                          // R9
    if (v < 0) v = 0;
    return v;
  endfunction

  task automatic cmp(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b (cnt model %0d)", req, act, exp, exp_cnt);
    end
  endtask

  task automatic check_outs();
    bit idle = (exp_cnt == 0);
    logic e_cmd, e_vram, e_dma, e_req;
    string rq;
    e_vram = idle && state == 2'd2;                                  // R1
    e_cmd  = idle && state == 2'd0;                                  // R2
    e_dma  = idle && (state == 2'd0 || (state != 2'd2 && pend != 0)); // R3
    case (dir)
      2'd1: begin e_req = idle && state >= 2'd2; rq = "R5"; end
      2'd2: begin e_req = e_dma;  rq = "R6"; end
      2'd3: begin e_req = e_vram; rq = "R7"; end
      default: begin e_req = 1'b0; rq = "R4"; end
    endcase
    cmp("R1", rdy_vram, e_vram);
    cmp("R2", rdy_cmd, e_cmd);
    cmp("R3", rdy_dma, e_dma);
    cmp(rq, dreq, e_req);
  endtask

  task automatic cyc(logic [1:0] s, logic [7:0] p, logic [1:0] d,
                     logic sb, logic [7:0] w, logic [3:0] t);
    @(negedge clk);
    state = s; pend = p; dir = d; stb = sb; wcnt = w; tick = t;
    #1 check_outs();
    @(posedge clk);
    exp_cnt = next_cnt(exp_cnt, s, sb, int'(w), int'(t));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R11: reset state, every direction
    for (int d = 0; d < 4; d++) cyc(2'd0, 8'd0, 2'(d), 1'b0, 8'd0, 4'd0);
    for (int d = 0; d < 4; d++) cyc(2'd2, 8'd0, 2'(d), 1'b0, 8'd0, 4'd0);
    // R8: strobe outside writing state is ignored
    cyc(2'd1, 8'd3, 2'd2, 1'b1, 8'd200, 4'd0);
    cyc(2'd0, 8'd0, 2'd2, 1'b0, 8'd0, 4'd0);
    cyc(2'd2, 8'd0, 2'd3, 1'b1, 8'd200, 4'd0);
    cyc(2'd2, 8'd0, 2'd3, 1'b0, 8'd0, 4'd0);
    // R8/R9: add 10, drain by 3: busy for exactly four cycles
    cyc(2'd3, 8'd0, 2'd1, 1'b1, 8'd10, 4'd0);
    for (int i = 0; i < 6; i++) cyc(2'd0, 8'd1, 2'(i % 4), 1'b0, 8'd0, 4'd3);
    // R9: overshoot clamps to zero
    cyc(2'd3, 8'd0, 2'd2, 1'b1, 8'd5, 4'd0);
    cyc(2'd0, 8'd0, 2'd2, 1'b0, 8'd0, 4'd15);
    cyc(2'd0, 8'd0, 2'd2, 1'b0, 8'd0, 4'd0);
    // R9: add and drain in one cycle net to zero
    cyc(2'd3, 8'd0, 2'd2, 1'b1, 8'd7, 4'd7);
    cyc(2'd1, 8'd2, 2'd2, 1'b0, 8'd0, 4'd0);
    // R10: saturate then drain
    for (int i = 0; i < 300; i++) cyc(2'd3, 8'd0, 2'd1, 1'b1, 8'd255, 4'd0);
    for (int i = 0; i < 4400; i++) cyc(2'(i % 4), 8'(i), 2'(i / 4), 1'b0, 8'd0, 4'd15);
    // Random mix
    for (int i = 0; i < 20000; i++) begin
      logic [1:0] s = 2'($urandom_range(0, 3));
      logic [7:0] p = ($urandom_range(0, 3) == 0) ? 8'd0 : 8'($urandom);
      logic       b = ($urandom_range(0, 2) == 0);
      logic [3:0] t = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'($urandom_range(0, 2));
      cyc(s, p, 2'($urandom), b, 8'($urandom_range(0, 40)), t);
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule